// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A behavioural, synthesizable model of a pipelined synchronous static RAM with a 48-bit word made of six byte lanes. Every access is issued on a single enabled clock edge: a new address is loaded, or the current four-word burst is advanced. Reads and writes can follow one another on consecutive edges with no idle cycles. This works because read data and write data both occupy the same bus slot: the cycle after the second enabled edge following the issue.

A host drives the address and control pins, and drives the data bus only during the slot of its own writes. It samples read data in the slot of its reads. An active-low clock enable freezes the whole pipeline, including the output register. Three chip selects gate new loads. An asynchronous output enable is combined with the synchronous drive control. The array depth is a parameter, so simulation stays small.

Top module: `ssram_pipe`

## Requirements
- R1: Inputs are captured on a rising clock edge only while `cke_n` is 0. While `cke_n` is 1, no state changes, `dq_o` and `dq_oe` hold their values, and no write reaches the array.
- R2: A load (`adv_ld`=0) starts an access only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination starts nothing, and `dq_oe` stays 0 in that operation's data slot.
- R3: A read issued at enabled edge E0 has its word on `dq_o` with `dq_oe`=1 from enabled edge E2 until the next enabled edge.
- R4: A write issued at enabled edge E0 takes its word from `dq_i` at enabled edge E3. The host therefore drives that word in the same slot that a read issued at E0 would occupy.
- R5: Lane k, meaning bits [8k+7:8k], is written only when `bw_n[k]`=0 as sampled with the operation's address. The other lanes keep their stored contents.
- R6: With `lin_ord`=1 at the load, each advance (`adv_ld`=1) uses the base address with its low two bits replaced by (start + count) mod 4. The count is the number of advances since the load.
- R7: With `lin_ord`=0 at the load, the low two bits on each advance are start XOR count, where count is two bits wide.
- R8: Advances after the fourth word keep wrapping the count modulo 4 and repeat the burst's operation type. An advance after reset, or after a deselected load, starts no access.
- R9: Reads and writes issued on consecutive enabled edges in any order each complete in their own slot, with no idle cycles.
- R10: A read issued on the edge right after a write to the same address returns the merged word from that write.
- R11: `dq_oe` is 0 during the data slot of a write.
- R12: `oe_n`=1 forces `dq_oe` to 0 immediately, without waiting for a clock edge.
- R13: After reset, `dq_oe` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the pipeline and burst state |
| cke_n | input | 1 | Active-low clock enable |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low, sampled on a load |
| bw_n | input | 6 | Per-lane write enables, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| lin_ord | input | 1 | Burst order at a load: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| dq_i | input | 48 | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 48 | Read data to the bus |
| dq_oe | output | 1 | Output drive enable for the data bus |

## Verification
A write's data capture and a read's array fetch can fall on the same enabled edge. This happens when a read to the same address is issued on the edge right after the write, so the fetch would see the array before the write lands. The bench provokes this with write-then-read pairs to one address, using both full and partial lane masks, and with a clock-enable stall placed between such operations. Each read slot is judged against a reference array that applies every write in issue order.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
    localparam int BURST_LEN  = 4;
    localparam int BURST_BITS = $clog2(BURST_LEN);

    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_SEQ = 1'b1
    } border_e;
endpackage

// File: rtl/ssram_burst_gen.sv
module ssram_burst_gen
    import ssram_pkg::*;
(
    input  logic [BURST_BITS-1:0] start_i,
    input  logic [BURST_BITS-1:0] cnt_i,
    input  border_e               order_i,
    output logic [BURST_BITS-1:0] low_o
);
    always_comb begin
        if (order_i == ORD_SEQ) low_o = start_i + cnt_i;
        else                    low_o = start_i ^ cnt_i;
    end
endmodule

// File: rtl/ssram_lane_merge.sv
module ssram_lane_merge #(
    parameter int LANES  = 6,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    old_i,
    input  logic [DW-1:0]    new_i,
    input  logic [LANES-1:0] bwn_i,
    output logic [DW-1:0]    res_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign res_o[k*LANE_W +: LANE_W] = bwn_i[k] ? old_i[k*LANE_W +: LANE_W]
                                                    : new_i[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/ssram_pipe.sv
module ssram_pipe
    import ssram_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 6,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             adv_ld,
    input  logic             lin_ord,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    dq_i,
    input  logic             oe_n,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe
);
    typedef struct packed {
        logic             vld;
        logic             we;
        logic [AW-1:0]    a;
        logic [LANES-1:0] bwn;
    } op_t;

    typedef struct packed {
        logic                  act;
        logic                  we;
        logic [AW-1:0]         base;
        logic [BURST_BITS-1:0] cnt;
        border_e               ord;
    } bst_t;

    typedef struct packed {
        bst_t          b;
        op_t           s1;
        op_t           s2;
        op_t           s3;
        logic          rvld;
        logic [DW-1:0] dout;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] mem [DEPTH];

    logic                  sel;
    logic [BURST_BITS-1:0] cnt_nx;
    logic [BURST_BITS-1:0] low_nx;
    logic [DW-1:0]         wr_word;
    logic [DW-1:0]         rd_word;
    logic                  commit;

    // signals observed by the bound checker
    logic          s1_vld, s2_rd, s2_wr, b_act, rvld;
    logic [DW-1:0] dout;

    assign sel    = !sel0_n && sel1 && !sel2_n;
    assign cnt_nx = st_q.b.cnt + BURST_BITS'(1);

    ssram_burst_gen u_burst (
        .start_i (st_q.b.base[BURST_BITS-1:0]),
        .cnt_i   (cnt_nx),
        .order_i (st_q.b.ord),
        .low_o   (low_nx)
    );

    ssram_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .old_i (mem[st_q.s3.a]),
        .new_i (dq_i),
        .bwn_i (st_q.s3.bwn),
        .res_o (wr_word)
    );

    assign commit  = !cke_n && st_q.s3.vld && st_q.s3.we;
    // a read fetching on the same edge that its predecessor write lands
    assign rd_word = (st_q.s3.vld && st_q.s3.we && st_q.s3.a == st_q.s2.a)
                     ? wr_word : mem[st_q.s2.a];

    always_comb begin
        st_d = st_q;
        if (!cke_n) begin
            if (!adv_ld) begin
                if (sel) begin
                    st_d.b  = '{act: 1'b1, we: !we_n, base: addr,
                                cnt: '0, ord: border_e'(lin_ord)};
                    st_d.s1 = '{vld: 1'b1, we: !we_n, a: addr, bwn: bw_n};
                end else begin
                    st_d.b.act  = 1'b0;
                    st_d.s1     = '0;
                end
            end else begin
                st_d.b.cnt  = cnt_nx;
                st_d.s1.vld = st_q.b.act;
                st_d.s1.we  = st_q.b.we;
                st_d.s1.a   = {st_q.b.base[AW-1:BURST_BITS], low_nx};
                st_d.s1.bwn = bw_n;
            end
            st_d.s2   = st_q.s1;
            st_d.s3   = st_q.s2;
            st_d.rvld = st_q.s2.vld && !st_q.s2.we;
            st_d.dout = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (commit) mem[st_q.s3.a] <= wr_word;
    end

    assign dq_o   = st_q.dout;
    assign dq_oe  = st_q.rvld && !oe_n;

    assign s1_vld = st_q.s1.vld;
    assign s2_rd  = st_q.s2.vld && !st_q.s2.we;
    assign s2_wr  = st_q.s2.vld && st_q.s2.we;
    assign b_act  = st_q.b.act;
    assign rvld   = st_q.rvld;
    assign dout   = st_q.dout;
endmodule

// File: rtl/ssram_chk.sv
module ssram_chk #(
    parameter int DW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          adv_ld,
    input logic          sel,
    input logic          s1_vld,
    input logic          s2_rd,
    input logic          s2_wr,
    input logic          b_act,
    input logic          rvld,
    input logic          dq_oe,
    input logic [DW-1:0] dout
);
    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(rvld) && $stable(s1_vld)));

    p_desel_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> !s1_vld);

    p_read_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_rd) |=> rvld);

    p_idle_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && !b_act) |=> !s1_vld);

    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_wr) |=> (!rvld && !dq_oe));
endmodule

bind ssram_pipe ssram_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke_n  (cke_n),
    .adv_ld (adv_ld),
    .sel    (sel),
    .s1_vld (s1_vld),
    .s2_rd  (s2_rd),
    .s2_wr  (s2_wr),
    .b_act  (b_act),
    .rvld   (rvld),
    .dq_oe  (dq_oe),
    .dout   (dout)
);

// File: tb/ssram_pipe_bench.sv
module ssram_pipe_bench;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int DW = 48;
    localparam int K_NONE = 0, K_RD = 1, K_WR = 2;

    logic clk = 0, rst_n = 0, cke_n = 1;
    logic sel0_n = 1, sel1 = 0, sel2_n = 1, we_n = 1, adv_ld = 0, lin_ord = 1, oe_n = 0;
    logic [5:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic dq_oe;

    ssram_pipe #(.AW(AW)) u_ssram_pipe (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .we_n(we_n), .bw_n(bw_n), .adv_ld(adv_ld), .lin_ord(lin_ord),
        .addr(addr), .dq_i(dq_i), .oe_n(oe_n), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    typedef struct {
        int            kind;
        logic [DW-1:0] d;
        string         req;
    } item_t;

    item_t q[$];
    logic [DW-1:0] refm [DEPTH];
    int checks = 0, failures = 0, serial = 0;
    bit oe_probe = 0;

    // independent burst model
    bit b_act = 0, b_we = 0, b_lin = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0] b_cnt = '0;

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the item whose data slot is the current cycle
    task automatic monitor_pop();
        item_t it;
        it = q.pop_front();
        if (it.kind == K_RD) begin
            check(dq_oe === 1'b1, {it.req, " oe"}, DW'(dq_oe), DW'(1));
            check(dq_o === it.d, it.req, dq_o, it.d);
            if (oe_probe) begin
                oe_n = 1'b1;
                #1;
                check(dq_oe === 1'b0, "R12 async oe", DW'(dq_oe), DW'(0));
                oe_n = 1'b0;
                oe_probe = 0;
            end
        end else begin
            dq_i = (it.kind == K_WR) ? it.d : ~dq_i;
            check(dq_oe === 1'b0, {it.req, " R11 no drive"}, DW'(dq_oe), DW'(0));
        end
    endtask

    // driver: one enabled clock issuing one command
    task automatic issue(bit adv, bit sel_ok, bit wr, logic [AW-1:0] a,
                         logic [5:0] bwn, bit lin, string req);
        item_t it;
        int kind;
        logic [AW-1:0] ea;
        logic [DW-1:0] wd;
        @(negedge clk);
        if (q.size() >= 3) monitor_pop();
        cke_n = 0; adv_ld = adv; we_n = !wr; addr = a; bw_n = bwn; lin_ord = lin;
        sel0_n = !sel_ok; sel1 = sel_ok; sel2_n = !sel_ok;
        ea = a;
        if (!adv) begin
            if (sel_ok) begin
                b_act = 1; b_we = wr; b_base = a; b_cnt = 0; b_lin = lin;
                kind = wr ? K_WR : K_RD;
            end else begin
                b_act = 0; kind = K_NONE;
            end
        end else begin
            b_cnt = b_cnt + 2'd1;
            ea = {b_base[AW-1:2], b_lin ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
            kind = b_act ? (b_we ? K_WR : K_RD) : K_NONE;
        end
        serial++;
        wd = {16'(serial * 977), 16'hC35A ^ 16'(serial), 8'(ea), 8'(serial)};
        it.kind = kind; it.req = req; it.d = '0;
        if (kind == K_WR) begin
            for (int k = 0; k < 6; k++)
                if (!bwn[k]) refm[ea][k*8 +: 8] = wd[k*8 +: 8];
            it.d = wd;
        end else if (kind == K_RD) begin
            it.d = refm[ea];
        end
        q.push_back(it);
    endtask

    task automatic ld(bit wr, logic [AW-1:0] a, logic [5:0] bwn, string req);
        issue(0, 1, wr, a, bwn, 1, req);
    endtask

    task automatic nop(int n);
        for (int i = 0; i < n; i++) issue(0, 0, 0, '0, '1, 1, "R2 deselect");
    endtask

    task automatic stall(int n);
        logic [DW-1:0] o;
        logic e;
        @(negedge clk);
        o = dq_o; e = dq_oe;
        cke_n = 1; adv_ld = 0; we_n = 0; addr = '0; bw_n = '0;
        sel0_n = 0; sel1 = 1; sel2_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(dq_o === o, "R1 stall holds dq_o", dq_o, o);
            check(dq_oe === e, "R1 stall holds dq_oe", DW'(dq_oe), DW'(e));
        end
    endtask

    initial begin
        #(20 * 200000);
        failures++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dq_oe === 1'b0, "R13 reset no drive", DW'(dq_oe), DW'(0));
        rst_n = 1;
        // R8: advance with no active burst after reset
        issue(1, 1, 1, 8'h40, '0, 1, "R8 idle advance");
        issue(1, 1, 0, 8'h40, '0, 1, "R8 idle advance");
        // fill the array
        for (int a = 0; a < DEPTH; a++) ld(1, 8'(a), '0, "R4 fill");
        nop(1);
        // R3: plain reads
        ld(0, 8'h10, '1, "R3 read"); ld(0, 8'hFE, '1, "R3 read"); ld(0, 8'h00, '1, "R3 read");
        // R9: alternating without idle
        ld(1, 8'h21, '0, "R9 wr"); ld(0, 8'h22, '1, "R9 rd"); ld(1, 8'h23, '0, "R9 wr");
        ld(0, 8'h21, '1, "R9 rd"); ld(0, 8'h23, '1, "R9 rd"); ld(1, 8'h22, '0, "R9 wr");
        // R10: write then read same address on the next edge
        ld(1, 8'h30, '0, "R10 wr"); ld(0, 8'h30, '1, "R10 rd fwd");
        ld(1, 8'h31, 6'b101010, "R10 partial wr"); ld(0, 8'h31, '1, "R10 rd merged");
        // R5: lane masks
        ld(1, 8'h50, 6'b111110, "R5 wr"); ld(1, 8'h50, 6'b011111, "R5 wr");
        ld(1, 8'h51, 6'b110011, "R5 wr"); nop(1);
        ld(0, 8'h50, '1, "R5 lanes"); ld(0, 8'h51, '1, "R5 lanes");
        // R6 + R8: linear read burst from low bits 2, six beats
        issue(0, 1, 0, 8'h06, '1, 1, "R6 linear");
        for (int i = 0; i < 5; i++) issue(1, 0, 1, '0, '0, 0, "R6 R8 linear wrap");
        // linear write burst from low bits 1, read back singly
        issue(0, 1, 1, 8'h09, '0, 1, "R6 linear wr");
        for (int i = 0; i < 3; i++) issue(1, 0, 0, '0, 6'(i * 9), 1, "R6 linear wr");
        for (int i = 8; i < 12; i++) ld(0, 8'(i), '1, "R6 readback");
        // R7: interleaved read burst from low bits 1, with wrap
        oe_probe = 1;
        issue(0, 1, 0, 8'h0D, '1, 0, "R7 interleaved");
        for (int i = 0; i < 5; i++) issue(1, 0, 1, '0, '0, 1, "R7 R8 interleaved");
        // interleaved write burst from low bits 3
        issue(0, 1, 1, 8'h77, '0, 0, "R7 interleaved wr");
        for (int i = 0; i < 3; i++) issue(1, 0, 0, '0, '0, 1, "R7 interleaved wr");
        for (int i = 116; i < 120; i++) ld(0, 8'(i), '1, "R7 readback");
        // R2: deselected load then advances start nothing
        issue(0, 0, 1, 8'h60, '0, 1, "R2 desel");
        issue(1, 1, 1, 8'h60, '0, 1, "R2 R8 adv after desel");
        issue(1, 1, 1, 8'h60, '0, 1, "R2 R8 adv after desel");
        ld(0, 8'h60, '1, "R2 untouched"); ld(0, 8'h61, '1, "R2 untouched");
        // R1: stall in a busy stream, garbage write held off
        ld(0, 8'h30, '1, "R1 rd"); ld(1, 8'h44, '0, "R1 wr"); ld(0, 8'h44, '1, "R1 rd fwd");
        stall(3);
        ld(1, 8'h45, 6'b000111, "R1 wr after stall"); ld(0, 8'h45, '1, "R1 rd");
        stall(2);
        ld(0, 8'h00, '1, "R1 addr0 untouched"); ld(0, 8'h44, '1, "R1 rd");
        nop(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule